// File: doc/BRIEF.md
# Tag-indexed miss tracking table for a non-blocking data cache

This block tracks outstanding load misses for a data cache whose processor names every request with a 9-bit identifier. The table holds one slot for each possible identifier value (512 slots), so a miss never waits for a free slot: the slot selected by the identifier is always empty, because the processor does not reuse an identifier that is still in flight. Each slot records a valid flag, the 43-bit block number (a 48-bit physical address with 32-byte blocks), the byte offset of the first byte within the block, and an access-size code.

When a miss arrives, the block number is compared with every valid slot at once. A memory request for the block goes out only when no valid slot already waits on it, so several misses to one block cost a single memory transfer. When memory returns a block, the block is sent on to the cache array write port. Every slot waiting on that block is then answered, one per cycle in ascending identifier order, with the identifier and the load data cut from the returned block. New refills are held off until the current one is fully answered. Answers can therefore come back in a different order from the requests.

Top module: `imshr`

## Requirements
- R1: After reset, `rspValid` and `memReqValid` are 0 and `fillReady` is 1.
- R2: A request whose block number (`reqAddr[47:5]`) matches no valid slot, no accepted refill and no held refill raises `memReqValid` in the next cycle, with `memReqBlk` equal to that block number.
- R3: A request whose block number matches a valid slot produces no memory request.
- R4: A refill accepted on a clock edge (`fillValid` and `fillReady` both 1) answers every slot waiting on its block. The answers are one per cycle in ascending `rspTag` order, the first one visible right after that edge, and each slot is freed as it is answered.
- R5: While answers for a refill are pending, `fillReady` is 0. A refill offered then is neither accepted nor forwarded to the cache write port.
- R6: `rspData` is the returned block read as little-endian bytes (byte i in bits 8i+7..8i), starting at the stored offset. It holds 1, 2, 4 or 8 bytes for size codes 0, 1, 2, 3 and is zero-extended to 64 bits. Bytes that would lie past the end of the block read as zero.
- R7: In the cycle a refill is accepted, `l1WrValid` is 1 and `l1WrBlk`/`l1WrData` equal the refill's block number and data.
- R8: A request that arrives in the same cycle as an accepted refill for its block joins that refill. It is answered from it and issues no memory request.
- R9: A request that arrives while a refill is being answered, for that refill's block, joins it. It issues no memory request and is answered in tag order among the slots still pending.
- R10: Once every slot of a block has been answered, a new request to that block issues a memory request again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A load miss is presented this cycle |
| reqTag | input | 9 | Identifier of the missing load |
| reqAddr | input | 48 | Physical byte address of the first byte |
| reqSize | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| memReqValid | output | 1 | Memory read request for a block |
| memReqBlk | output | 43 | Block number of the memory request |
| fillValid | input | 1 | Memory offers a returned block |
| fillReady | output | 1 | Refill is accepted when this and fillValid are both 1 |
| fillBlk | input | 43 | Block number of the returned block |
| fillData | input | 256 | Returned block contents |
| l1WrValid | output | 1 | Write of the accepted block into the cache array |
| l1WrBlk | output | 43 | Block number to write |
| l1WrData | output | 256 | Block contents to write |
| rspValid | output | 1 | A completed load is presented |
| rspTag | output | 9 | Identifier of the completed load |
| rspData | output | 64 | Zero-extended load data |

## Verification
The hardest case to reach is a refill whose answering is altered while it is in progress. One way is a miss to the same block that lands on the exact edge the refill is accepted. Another is a miss that arrives mid-drain with an identifier lower than the slots still pending, so it must jump ahead of them in the answer order. A directed sequence lines these up on chosen edges while a second refill is held at the port, and a long random phase then mixes misses and refills over a few blocks. Every cycle is compared against a behavioural model that keeps its own per-identifier records and pending set.

// File: rtl/imshr_pkg.sv
package imshr_pkg;
  // Strobes from the sequencing control to the table datapath.
  typedef struct packed {
    logic wrEn;      // record the presented miss in its slot
    logic loadHold;  // capture the accepted refill
    logic retire;    // free the slot answered this cycle
    logic issue;     // register a memory request for the presented block
  } ctlStrb_t;
endpackage

// File: rtl/imshr_dp.sv
module imshr_dp
  import imshr_pkg::*;
#(
  parameter int TAG_W  = 9,
  parameter int ADDR_W = 48,
  parameter int OFF_W  = 5,
  parameter int SZ_W   = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctlStrb_t                      strb,
  input  logic [TAG_W-1:0]              retTag,
  input  logic [TAG_W-1:0]              reqTag,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [SZ_W-1:0]               reqSize,
  input  logic [ADDR_W-OFF_W-1:0]       fillBlk,
  input  logic [(8<<OFF_W)-1:0]         fillData,
  output logic                          reqHitAny,
  output logic [(1<<TAG_W)-1:0]         fillHitVec,
  output logic                          reqEqFill,
  output logic                          reqEqHold,
  output logic [ADDR_W-OFF_W-1:0]       memReqBlk,
  output logic [(8<<((1<<SZ_W)-1))-1:0] rspData
);
  localparam int N      = 1 << TAG_W;
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int LINE_W = 8 << OFF_W;
  localparam int RSP_W  = 8 << ((1 << SZ_W) - 1);

  logic [N-1:0]       validQ;
  logic [BLK_W-1:0]   blkQ  [N];
  logic [OFF_W-1:0]   offQ  [N];
  logic [SZ_W-1:0]    sizeQ [N];
  logic [BLK_W-1:0]   holdBlkQ;
  logic [LINE_W-1:0]  holdDataQ;
  logic [N-1:0]       reqHitVec;

  logic [BLK_W-1:0] reqBlk;
  logic [OFF_W-1:0] reqOff;
  assign reqBlk = reqAddr[ADDR_W-1:OFF_W];
  assign reqOff = reqAddr[OFF_W-1:0];

  // Associative compare banks: one against the presented miss, one against the refill.
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign reqHitVec[i]  = validQ[i] && (blkQ[i] == reqBlk);
    assign fillHitVec[i] = validQ[i] && (blkQ[i] == fillBlk);
  end

  assign reqHitAny = |reqHitVec;
  assign reqEqFill = (reqBlk == fillBlk);
  assign reqEqHold = (reqBlk == holdBlkQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else begin
      if (strb.retire) validQ[retTag] <= 1'b0;
      if (strb.wrEn)   validQ[reqTag] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      blkQ[reqTag]  <= reqBlk;
      offQ[reqTag]  <= reqOff;
      sizeQ[reqTag] <= reqSize;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdBlkQ  <= '0;
      holdDataQ <= '0;
      memReqBlk <= '0;
    end else begin
      if (strb.loadHold) begin
        holdBlkQ  <= fillBlk;
        holdDataQ <= fillData;
      end
      if (strb.issue) memReqBlk <= reqBlk;
    end
  end

  // Load data extraction for the slot being answered.
  logic [LINE_W-1:0] shifted;
  logic [RSP_W-1:0]  byteMask;
  logic [SZ_W-1:0]   sizeSel;

  assign shifted = holdDataQ >> {offQ[retTag], 3'b000};
  assign sizeSel = sizeQ[retTag];

  always_comb begin
    byteMask = '0;
    for (int b = 0; b < RSP_W / 8; b++) begin
      if (b < (1 << sizeSel)) byteMask[b*8 +: 8] = 8'hFF;
    end
  end

  assign rspData = shifted[RSP_W-1:0] & byteMask;
endmodule

// File: rtl/imshr_ctl.sv
module imshr_ctl
  import imshr_pkg::*;
#(
  parameter int TAG_W = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [TAG_W-1:0]      reqTag,
  input  logic                  fillValid,
  input  logic                  reqHitAny,
  input  logic [(1<<TAG_W)-1:0] fillHitVec,
  input  logic                  reqEqFill,
  input  logic                  reqEqHold,
  output ctlStrb_t              strb,
  output logic [TAG_W-1:0]      retTag,
  output logic                  rspValid,
  output logic                  fillReady,
  output logic                  memReqValid
);
  localparam int N = 1 << TAG_W;
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] pendQ;
  logic [N-1:0] pendNext;
  logic [N-1:0] joinVec;
  logic         busy;
  logic         accept;
  logic         joinReq;

  assign busy   = |pendQ;
  assign accept = fillValid && !busy;

  // Lowest pending identifier is answered first.
  always_comb begin
    retTag = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pendQ[i]) retTag = TAG_W'(i);
    end
  end

  assign joinReq = reqValid && ((accept && reqEqFill) || (busy && reqEqHold));
  assign joinVec = joinReq ? (ONE << reqTag) : '0;

  always_comb begin
    if (accept)    pendNext = fillHitVec | joinVec;
    else if (busy) pendNext = (pendQ & ~(ONE << retTag)) | joinVec;
    else           pendNext = joinVec;
  end

  always_comb begin
    strb.wrEn     = reqValid;
    strb.loadHold = accept;
    strb.retire   = busy;
    strb.issue    = reqValid && !reqHitAny && !joinReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ       <= '0;
      memReqValid <= 1'b0;
    end else begin
      pendQ       <= pendNext;
      memReqValid <= strb.issue;
    end
  end

  assign rspValid  = busy;
  assign fillReady = !busy;
endmodule

// File: rtl/imshr.sv
module imshr
  import imshr_pkg::*;
#(
  parameter int TAG_W  = 9,
  parameter int ADDR_W = 48,
  parameter int OFF_W  = 5,
  parameter int SZ_W   = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic [TAG_W-1:0]              reqTag,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [SZ_W-1:0]               reqSize,
  output logic                          memReqValid,
  output logic [ADDR_W-OFF_W-1:0]       memReqBlk,
  input  logic                          fillValid,
  output logic                          fillReady,
  input  logic [ADDR_W-OFF_W-1:0]       fillBlk,
  input  logic [(8<<OFF_W)-1:0]         fillData,
  output logic                          l1WrValid,
  output logic [ADDR_W-OFF_W-1:0]       l1WrBlk,
  output logic [(8<<OFF_W)-1:0]         l1WrData,
  output logic                          rspValid,
  output logic [TAG_W-1:0]              rspTag,
  output logic [(8<<((1<<SZ_W)-1))-1:0] rspData
);
  localparam int N = 1 << TAG_W;

  ctlStrb_t     strb;
  logic         reqHitAny;
  logic [N-1:0] fillHitVec;
  logic         reqEqFill;
  logic         reqEqHold;

  imshr_ctl #(.TAG_W(TAG_W)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTag(reqTag),
    .fillValid(fillValid), .reqHitAny(reqHitAny), .fillHitVec(fillHitVec),
    .reqEqFill(reqEqFill), .reqEqHold(reqEqHold), .strb(strb),
    .retTag(rspTag), .rspValid(rspValid), .fillReady(fillReady),
    .memReqValid(memReqValid)
  );

  imshr_dp #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SZ_W(SZ_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .retTag(rspTag), .reqTag(reqTag),
    .reqAddr(reqAddr), .reqSize(reqSize), .fillBlk(fillBlk), .fillData(fillData),
    .reqHitAny(reqHitAny), .fillHitVec(fillHitVec), .reqEqFill(reqEqFill),
    .reqEqHold(reqEqHold), .memReqBlk(memReqBlk), .rspData(rspData)
  );

  assign l1WrValid = fillValid && fillReady;
  assign l1WrBlk   = fillBlk;
  assign l1WrData  = fillData;
endmodule

// File: rtl/imshr_chk.sv
module imshr_chk #(
  parameter int TAG_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             fillValid,
  input logic             fillReady,
  input logic             rspValid,
  input logic [TAG_W-1:0] rspTag,
  input logic             memReqValid
);
  // R5
  rsp_blocks_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !fillReady);

  // R2
  memreq_needs_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> $past(reqValid));

  // R4
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) |-> $past(fillValid && fillReady));

  // R4
  rsp_tag_advances_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(rspValid)) |-> (rspTag != $past(rspTag)));
endmodule

bind imshr imshr_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .fillValid(fillValid),
  .fillReady(fillReady), .rspValid(rspValid), .rspTag(rspTag),
  .memReqValid(memReqValid)
);

// File: tb/imshr_tb.sv
`timescale 1ns/100ps
module imshr_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic [8:0]   reqTag = '0;
  logic [47:0]  reqAddr = '0;
  logic [1:0]   reqSize = '0;
  logic         memReqValid;
  logic [42:0]  memReqBlk;
  logic         fillValid = 1'b0;
  logic         fillReady;
  logic [42:0]  fillBlk = '0;
  logic [255:0] fillData = '0;
  logic         l1WrValid;
  logic [42:0]  l1WrBlk;
  logic [255:0] l1WrData;
  logic         rspValid;
  logic [8:0]   rspTag;
  logic [63:0]  rspData;

  imshr u_dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          mValid [512];
  bit          mPend  [512];
  logic [47:0] mAddr  [512];
  logic [1:0]  mSize  [512];
  logic [255:0] holdM;
  logic [42:0]  holdBlkM;
  bit           expMemV;
  logic [42:0]  expMemBlk;

  function automatic int firstPend();
    for (int t = 0; t < 512; t++) if (mPend[t]) return t;
    return -1;
  endfunction

  function automatic logic [63:0] cut(input logic [255:0] d, input int off, input int sz);
    logic [63:0] r = '0;
    for (int b = 0; b < (1 << sz); b++)
      if (off + b < 32) r[b*8 +: 8] = d[(off+b)*8 +: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < 512; t++) begin mValid[t] = 0; mPend[t] = 0; end
      expMemV = 0; expMemBlk = '0; holdM = '0; holdBlkM = '0;
    end else begin
      int  lo;
      bit  acc, hit, jn;
      logic [42:0] rb;
      lo  = firstPend();
      acc = fillValid && (lo < 0);
      rb  = reqAddr[47:5];
      hit = 0;
      for (int t = 0; t < 512; t++) if (mValid[t] && mAddr[t][47:5] == rb) hit = 1;
      jn = reqValid && ((acc && rb == fillBlk) || (lo >= 0 && rb == holdBlkM));
      if (lo >= 0) begin mPend[lo] = 0; mValid[lo] = 0; end
      if (acc) begin
        for (int t = 0; t < 512; t++) if (mValid[t] && mAddr[t][47:5] == fillBlk) mPend[t] = 1;
        holdM = fillData; holdBlkM = fillBlk;
      end
      if (reqValid) begin
        mValid[reqTag] = 1; mAddr[reqTag] = reqAddr; mSize[reqTag] = reqSize;
        if (jn) mPend[reqTag] = 1;
      end
      expMemV = reqValid && !hit && !jn;
      if (expMemV) expMemBlk = rb;
    end
  end

  int          rspLog[$];
  logic [63:0] capData [512];

  // Cycle compare against the model, away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      int lo;
      lo = firstPend();
      chk(rspValid == (lo >= 0), "R4", "rspValid", rspValid, lo >= 0);
      chk(fillReady == (lo < 0), "R5", "fillReady", fillReady, lo < 0);
      chk(memReqValid == expMemV, "R2", "memReqValid", memReqValid, expMemV);
      if (expMemV) chk(memReqBlk == expMemBlk, "R2", "memReqBlk", memReqBlk, expMemBlk);
      if (lo >= 0) begin
        chk(rspTag == 9'(lo), "R4", "rspTag", rspTag, lo);
        chk(rspData == cut(holdM, int'(mAddr[lo][4:0]), int'(mSize[lo])), "R6", "rspData",
            rspData, cut(holdM, int'(mAddr[lo][4:0]), int'(mSize[lo])));
      end
      if (rspValid) begin rspLog.push_back(int'(rspTag)); capData[rspTag] = rspData; end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog (R1..R10 run) actual=%0d expected=<100000 cycles", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic doReq(input int tag, input logic [47:0] a, input int sz);
    reqValid = 1; reqTag = 9'(tag); reqAddr = a; reqSize = 2'(sz);
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic doFill(input logic [42:0] b, input logic [255:0] d);
    fillBlk = b; fillData = d; fillValid = 1;
    while (fillReady !== 1'b1) @(negedge clk);
    @(negedge clk);
    fillValid = 0;
  endtask

  task automatic waitIdle();
    while (fillReady !== 1'b1) @(negedge clk);
  endtask

  localparam logic [42:0] B1 = 43'h1234;
  localparam logic [42:0] B2 = 43'h0777;
  localparam logic [42:0] B3 = 43'h0abc;

  initial begin
    logic [255:0] d3;
    int expSeq[5];
    for (int i = 0; i < 32; i++) d3[i*8 +: 8] = 8'h40 + 8'(i);
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    chk(rspValid == 0 && memReqValid == 0 && fillReady == 1, "R1", "reset outputs",
        {rspValid, memReqValid, fillReady}, 3'b001);

    // R2: fresh block
    doReq(5, {B1, 5'd8}, 3);
    chk(memReqValid == 1 && memReqBlk == B1, "R2", "first miss issues", {memReqValid, memReqBlk}, {1'b1, B1});
    // R3: same block again
    doReq(2, {B1, 5'd4}, 1);
    chk(memReqValid == 0, "R3", "second miss suppressed", memReqValid, 0);
    doReq(9, {B1, 5'd31}, 0);
    chk(memReqValid == 0, "R3", "third miss suppressed", memReqValid, 0);

    // R7 / R8: refill accepted with a same-cycle miss on the block
    rspLog.delete();
    fillBlk = B1; fillData = {8{32'hdeadbeef}}; fillValid = 1;
    reqValid = 1; reqTag = 9'd7; reqAddr = {B1, 5'd0}; reqSize = 2'd2;
    #1;
    chk(l1WrValid == 1 && l1WrBlk == B1 && l1WrData == {8{32'hdeadbeef}}, "R7", "cache write",
        {l1WrValid, l1WrBlk}, {1'b1, B1});
    @(negedge clk);
    fillValid = 0; reqValid = 0;
    chk(memReqValid == 0, "R8", "joined miss issues nothing", memReqValid, 0);
    chk(rspValid == 1 && rspTag == 9'd2, "R4", "first answer lowest tag", rspTag, 2);
    // R9 / R5: lower-tag miss during drain, and a second refill held off
    reqValid = 1; reqTag = 9'd1; reqAddr = {B1, 5'd2}; reqSize = 2'd1;
    fillBlk = B2; fillData = '1; fillValid = 1;
    #1;
    chk(fillReady == 0 && l1WrValid == 0, "R5", "refill held while draining", {fillReady, l1WrValid}, 2'b00);
    @(negedge clk);
    reqValid = 0;
    chk(memReqValid == 0, "R9", "mid-drain miss issues nothing", memReqValid, 0);
    chk(rspValid == 1 && rspTag == 9'd1, "R9", "mid-drain miss answered next", rspTag, 1);
    while (fillReady !== 1'b1) @(negedge clk);
    @(negedge clk);
    fillValid = 0;
    waitIdle();
    expSeq = '{2, 1, 5, 7, 9};
    chk(rspLog.size() == 5, "R4", "answer count", rspLog.size(), 5);
    for (int i = 0; i < 5 && i < rspLog.size(); i++)
      chk(rspLog[i] == expSeq[i], "R4", "answer order", rspLog[i], expSeq[i]);

    // R10: block freed
    doReq(3, {B1, 5'd0}, 3);
    chk(memReqValid == 1 && memReqBlk == B1, "R10", "freed block issues again", {memReqValid, memReqBlk}, {1'b1, B1});
    doFill(B1, '0);
    waitIdle();

    // R6: extraction across sizes and a block-end overrun
    doReq(20, {B3, 5'd0}, 3);
    doReq(21, {B3, 5'd30}, 2);
    doReq(22, {B3, 5'd7}, 0);
    doReq(23, {B3, 5'd16}, 1);
    doFill(B3, d3);
    waitIdle();
    chk(capData[20] == 64'h4746454443424140, "R6", "8 bytes at 0", capData[20], 64'h4746454443424140);
    chk(capData[21] == 64'h5f5e, "R6", "4 bytes at 30 zero past end", capData[21], 64'h5f5e);
    chk(capData[22] == 64'h47, "R6", "1 byte at 7", capData[22], 64'h47);
    chk(capData[23] == 64'h5150, "R6", "2 bytes at 16", capData[23], 64'h5150);

    // Random mix, compared cycle by cycle
    for (int c = 0; c < 4000; c++) begin
      int tg;
      tg = int'($urandom_range(0, 511));
      if ($urandom_range(0, 2) == 0 && !mValid[tg]) begin
        reqValid = 1; reqTag = 9'(tg);
        reqAddr = {43'h200 + 43'($urandom_range(0, 3)), 5'($urandom_range(0, 31))};
        reqSize = 2'($urandom_range(0, 3));
      end else reqValid = 0;
      if ($urandom_range(0, 5) == 0) begin
        fillValid = 1; fillBlk = 43'h200 + 43'($urandom_range(0, 3));
        for (int w = 0; w < 8; w++) fillData[w*32 +: 32] = $urandom;
      end else fillValid = 0;
      @(negedge clk);
    end
    reqValid = 0; fillValid = 0;
    for (int b = 0; b < 4; b++) begin
      waitIdle();
      doFill(43'h200 + 43'(b), {8{32'h0f1e2d3c}});
    end
    waitIdle();
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule